// File: doc/BRIEF.md
# Coherent Port Snoop and DVM Enable Controller

This block controls whether each slave port of a coherent interconnect takes part in snoop traffic and in distributed virtual memory (DVM) message traffic. Software writes a two-bit enable value into a port's control register. That write does not change the port at once. It starts a request/acknowledge handshake with the port's request logic, and the new enables reach the port outputs only when the port acknowledges.

A shared status register shows whether any port still has a change in progress. After each control write, software polls that bit until it reads zero. Writes that arrive while a change is in flight are held as the port's next target, and the most recent one wins.

When a change would switch snoops off on a port that still has snoop transactions in flight, the request is held back until the port's outstanding count drains to zero. Ports come in two kinds, set by parameters: full coherent ports first, then lite I/O-coherent ports. On a lite port the DVM bit is masked off.

Top module: `coh_port_enable_ctrl`

## Requirements
- R1: After a synchronous reset, every port has snoop and DVM disabled, no change request is raised, and the status bit reads 0.
- R2: A write to byte offset 0x0 of port k's window (address (k+1)·4096) sets that port's target value, with bit 0 = snoop enable and bit 1 = DVM enable. One cycle after the write is captured, chg_req[k] rises, carrying the target on chg_snoop[k]/chg_dvm[k] (unless R7 holds it back).
- R3: snoop_en[k]/dvm_en[k] change only in the cycle after a clock edge where chg_req[k] and chg_ack[k] are both high; they then take the offered value and chg_req[k] falls.
- R4: Bit 0 of the status register (control window, address 0x000C) reads 1 while any port has a captured write not yet acknowledged, and reads 0 once all are acknowledged.
- R5: While chg_req[k] is high and no acknowledge has arrived, chg_req[k], chg_snoop[k] and chg_dvm[k] hold steady.
- R6: Writes to a port whose change is in flight are accepted; after the acknowledge, a new request is raised carrying the last value written.
- R7: A change that clears snoop enable on a port whose outstanding snoop count (snp_start pulses minus snp_end pulses) is non-zero does not raise chg_req until the count reaches zero. Changes that leave snoop enabled are not held.
- R8: On lite ports (indices NUM_FULL and up), the DVM bit of a write is ignored: chg_dvm and dvm_en stay 0.
- R9: A read of a port's control register returns its applied enables in bits 1:0. Reads of unmapped addresses return 0, and writes to unmapped addresses start no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | DATA_W | Read data, valid the cycle after rd_en |
| snp_start | input | NUM_FULL+NUM_LITE | Per port: one snoop transaction issued |
| snp_end | input | NUM_FULL+NUM_LITE | Per port: one snoop transaction completed |
| chg_ack | input | NUM_FULL+NUM_LITE | Per port: acknowledge of the offered change |
| chg_req | output | NUM_FULL+NUM_LITE | Per port: change request toward port logic |
| chg_snoop | output | NUM_FULL+NUM_LITE | Per port: offered snoop enable |
| chg_dvm | output | NUM_FULL+NUM_LITE | Per port: offered DVM enable |
| snoop_en | output | NUM_FULL+NUM_LITE | Per port: applied snoop enable |
| dvm_en | output | NUM_FULL+NUM_LITE | Per port: applied DVM enable |

## Verification
The bench builds the block with two full ports and three lite ports, a 16-bit address and a 3-bit outstanding counter. The mix of port kinds lets one stimulus table exercise both the unmasked and the masked DVM path. With five ports, window 6 lies past the last port and serves as an unmapped address. The small counter keeps the drain scenario short while still covering counts of two down to zero.

// File: rtl/coh_port_enable_pkg.sv
package coh_port_enable_pkg;

  // Two enable bits per port; dvm sits above snoop so the packed value
  // lines up with the control register layout (bit0 snoop, bit1 dvm).
  typedef struct packed {
    logic dvm;
    logic snoop;
  } en_pair_t;

  localparam int WIN_SHIFT      = 12;      // 4 KiB register windows
  localparam int CTRL_OFFSET    = 'h000;   // control word inside a port window
  localparam int STATUS_OFFSET  = 'h00C;   // status word inside the control window
  localparam int STATUS_BUSY_BIT = 0;

endpackage

// File: rtl/pcen_addr_dec.sv
module pcen_addr_dec
  import coh_port_enable_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_PORTS = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_PORTS-1:0] port_hit,
  output logic                 status_hit
);

  localparam int WIN_W = ADDR_W - WIN_SHIFT;

  logic [WIN_W-1:0]     win;
  logic [WIN_SHIFT-1:0] off;

  assign win = addr[ADDR_W-1:WIN_SHIFT];
  assign off = addr[WIN_SHIFT-1:0];

  assign status_hit = (win == '0) && (off == WIN_SHIFT'(STATUS_OFFSET));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_hit
    assign port_hit[i] = (win == WIN_W'(i + 1)) && (off == WIN_SHIFT'(CTRL_OFFSET));
  end

endmodule

// File: rtl/pcen_port_agent.sv
module pcen_port_agent
  import coh_port_enable_pkg::*;
#(
  parameter bit IS_LITE = 1'b0,
  parameter int CNT_W   = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_hit,
  input  en_pair_t wr_val,
  input  logic     snp_start,
  input  logic     snp_end,
  input  logic     chg_ack,
  output logic     chg_req,
  output en_pair_t chg_val,
  output en_pair_t applied,
  output logic     pending
);

  en_pair_t         tgt_q;
  logic             queued_q;
  logic [CNT_W-1:0] cnt_q;
  en_pair_t         wr_masked;
  logic             drain_block;
  logic             issue;

  // Lite ports carry no DVM enable: the bit is dropped at capture.
  if (IS_LITE) begin : g_lite
    assign wr_masked = {1'b0, wr_val.snoop};
  end else begin : g_full
    assign wr_masked = wr_val;
  end

  // Outstanding snoop tracker; saturates at both ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({snp_start, snp_end})
        2'b10:   if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  // Switching snoops off waits for in-flight snoops to finish.
  assign drain_block = applied.snoop && !tgt_q.snoop && (cnt_q != '0);
  assign issue       = queued_q && !chg_req && !drain_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q    <= '0;
      queued_q <= 1'b0;
      chg_req  <= 1'b0;
      chg_val  <= '0;
      applied  <= '0;
    end else begin
      if (chg_req && chg_ack) begin
        applied <= chg_val;
        chg_req <= 1'b0;
      end
      if (issue) begin
        chg_req  <= 1'b1;
        chg_val  <= tgt_q;
        queued_q <= 1'b0;
      end
      // A write in the same cycle as an issue becomes the next target.
      if (wr_hit) begin
        tgt_q    <= wr_masked;
        queued_q <= 1'b1;
      end
    end
  end

  assign pending = queued_q | chg_req;

endmodule

// File: rtl/pcen_rd_mux.sv
module pcen_rd_mux
  import coh_port_enable_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [NUM_PORTS-1:0] port_hit,
  input  logic                 status_hit,
  input  en_pair_t             applied [NUM_PORTS],
  input  logic                 busy,
  output logic [DATA_W-1:0]    rd_data
);

  en_pair_t sel_val;

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (port_hit[i]) sel_val = sel_val | applied[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (status_hit)       rd_data[STATUS_BUSY_BIT] <= busy;
      else if (|port_hit)   rd_data[1:0] <= sel_val;
    end
  end

endmodule

// File: rtl/coh_port_enable_ctrl.sv
module coh_port_enable_ctrl
  import coh_port_enable_pkg::*;
#(
  parameter int NUM_FULL = 2,
  parameter int NUM_LITE = 3,
  parameter int CNT_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [NUM_FULL+NUM_LITE-1:0] snp_start,
  input  logic [NUM_FULL+NUM_LITE-1:0] snp_end,
  input  logic [NUM_FULL+NUM_LITE-1:0] chg_ack,
  output logic [NUM_FULL+NUM_LITE-1:0] chg_req,
  output logic [NUM_FULL+NUM_LITE-1:0] chg_snoop,
  output logic [NUM_FULL+NUM_LITE-1:0] chg_dvm,
  output logic [NUM_FULL+NUM_LITE-1:0] snoop_en,
  output logic [NUM_FULL+NUM_LITE-1:0] dvm_en
);

  localparam int NUM_PORTS = NUM_FULL + NUM_LITE;

  logic [NUM_PORTS-1:0] wr_port_hit;
  logic                 wr_status_hit;
  logic [NUM_PORTS-1:0] rd_port_hit;
  logic                 rd_status_hit;
  logic [NUM_PORTS-1:0] pend;
  en_pair_t             applied [NUM_PORTS];
  en_pair_t             offered [NUM_PORTS];
  en_pair_t             wr_val;
  logic                 unused_wr;

  assign wr_val    = wr_data[1:0];
  assign unused_wr = ^{wr_data[DATA_W-1:2], wr_status_hit};

  pcen_addr_dec #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_wr_dec (
    .addr       (wr_addr),
    .port_hit   (wr_port_hit),
    .status_hit (wr_status_hit)
  );

  pcen_addr_dec #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_rd_dec (
    .addr       (rd_addr),
    .port_hit   (rd_port_hit),
    .status_hit (rd_status_hit)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    pcen_port_agent #(.IS_LITE(i >= NUM_FULL), .CNT_W(CNT_W)) u_agent (
      .clk       (clk),
      .rst       (rst),
      .wr_hit    (wr_en && wr_port_hit[i]),
      .wr_val    (wr_val),
      .snp_start (snp_start[i]),
      .snp_end   (snp_end[i]),
      .chg_ack   (chg_ack[i]),
      .chg_req   (chg_req[i]),
      .chg_val   (offered[i]),
      .applied   (applied[i]),
      .pending   (pend[i])
    );
    assign chg_snoop[i] = offered[i].snoop;
    assign chg_dvm[i]   = offered[i].dvm;
    assign snoop_en[i]  = applied[i].snoop;
    assign dvm_en[i]    = applied[i].dvm;
  end

  pcen_rd_mux #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) u_rd_mux (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .port_hit   (rd_port_hit),
    .status_hit (rd_status_hit),
    .applied    (applied),
    .busy       (|pend),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/coh_port_enable_ctrl_chk.sv
module coh_port_enable_ctrl_chk #(
  parameter int NUM_FULL = 2,
  parameter int NUM_LITE = 3,
  parameter int CNT_W    = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_FULL+NUM_LITE-1:0] snp_start,
  input logic [NUM_FULL+NUM_LITE-1:0] snp_end,
  input logic [NUM_FULL+NUM_LITE-1:0] chg_ack,
  input logic [NUM_FULL+NUM_LITE-1:0] chg_req,
  input logic [NUM_FULL+NUM_LITE-1:0] chg_snoop,
  input logic [NUM_FULL+NUM_LITE-1:0] chg_dvm,
  input logic [NUM_FULL+NUM_LITE-1:0] snoop_en,
  input logic [NUM_FULL+NUM_LITE-1:0] dvm_en
);

  localparam int NUM_PORTS = NUM_FULL + NUM_LITE;

  // R1: reset leaves everything off
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (chg_req == '0) && (snoop_en == '0) && (dvm_en == '0));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    logic [CNT_W-1:0] seen_cnt;

    always_ff @(posedge clk) begin
      if (rst) seen_cnt <= '0;
      else if (snp_start[i] && !snp_end[i] && seen_cnt != '1) seen_cnt <= seen_cnt + 1'b1;
      else if (snp_end[i] && !snp_start[i] && seen_cnt != '0) seen_cnt <= seen_cnt - 1'b1;
    end

    p_apply_on_ack_r3: assert property (@(posedge clk) disable iff (rst)
      chg_req[i] && chg_ack[i] |=>
        !chg_req[i] && snoop_en[i] == $past(chg_snoop[i]) && dvm_en[i] == $past(chg_dvm[i]));

    p_en_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !(chg_req[i] && chg_ack[i]) |=> $stable(snoop_en[i]) && $stable(dvm_en[i]));

    p_offer_stable_r5: assert property (@(posedge clk) disable iff (rst)
      chg_req[i] && !chg_ack[i] |=> chg_req[i] && $stable(chg_snoop[i]) && $stable(chg_dvm[i]));

    p_drain_first_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(chg_req[i]) && snoop_en[i] && !chg_snoop[i] |-> $past(seen_cnt) == '0);

    if (i >= NUM_FULL) begin : g_lite
      p_lite_no_dvm_r8: assert property (@(posedge clk) disable iff (rst)
        !dvm_en[i] && !chg_dvm[i]);
    end
  end

endmodule

bind coh_port_enable_ctrl coh_port_enable_ctrl_chk #(
  .NUM_FULL (NUM_FULL),
  .NUM_LITE (NUM_LITE),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .snp_start (snp_start),
  .snp_end   (snp_end),
  .chg_ack   (chg_ack),
  .chg_req   (chg_req),
  .chg_snoop (chg_snoop),
  .chg_dvm   (chg_dvm),
  .snoop_en  (snoop_en),
  .dvm_en    (dvm_en)
);

// File: tb/coh_port_enable_ctrl_test.sv
`timescale 1ns/1ps
module coh_port_enable_ctrl_test;

  localparam int NF = 2;
  localparam int NL = 3;
  localparam int NP = NF + NL;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] STAT_ADDR = 16'h000C;

  // {port[7:4], write data[3:2], expected applied {dvm,snoop}[1:0]}
  localparam logic [7:0] VEC [8] = '{8'h0F, 8'h00, 8'h15, 8'h1A,
                                     8'h2D, 8'h28, 8'h4D, 8'h35};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NP-1:0] snp_start = '0, snp_end = '0, chg_ack = '0;
  logic [NP-1:0] chg_req, chg_snoop, chg_dvm, snoop_en, dvm_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] rv;

  always #4 clk = ~clk;

  coh_port_enable_ctrl #(.NUM_FULL(NF), .NUM_LITE(NL), .CNT_W(3),
                         .ADDR_W(AW), .DATA_W(DW)) uut (.*);

  function automatic logic [AW-1:0] port_addr(input int p);
    return AW'((p + 1) << 12);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic ack(input int p);
    chg_ack[p] = 1'b1;
    @(negedge clk);
    chg_ack[p] = 1'b0;
  endtask

  task automatic pulse_start(input int p);
    snp_start[p] = 1'b1;
    @(negedge clk);
    snp_start[p] = 1'b0;
  endtask

  task automatic pulse_end(input int p);
    snp_end[p] = 1'b1;
    @(negedge clk);
    snp_end[p] = 1'b0;
  endtask

  task automatic apply(input int p, input logic [1:0] d);
    wr(port_addr(p), DW'(d));
    step(1);
    ack(p);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);

    // R1: reset state
    chk(chg_req == '0, "R1 chg_req", int'(chg_req), 0);
    chk(snoop_en == '0 && dvm_en == '0, "R1 enables", int'({dvm_en, snoop_en}), 0);
    rd(STAT_ADDR, rv);
    chk(rv == 0, "R1 status", int'(rv), 0);

    // Table of writes: R2, R3, R4, R8, R9
    for (int i = 0; i < 8; i++) begin
      int p;
      logic [1:0] d, e;
      p = int'(VEC[i][7:4]);
      d = VEC[i][3:2];
      e = VEC[i][1:0];
      wr(port_addr(p), DW'(d));
      rd(STAT_ADDR, rv);
      chk(rv[0] == 1'b1, "R4 busy after write", int'(rv[0]), 1);
      chk(chg_req[p] == 1'b1, "R2 request raised", int'(chg_req[p]), 1);
      chk({chg_dvm[p], chg_snoop[p]} == e, "R2/R8 offered value",
          int'({chg_dvm[p], chg_snoop[p]}), int'(e));
      ack(p);
      chk({dvm_en[p], snoop_en[p]} == e, "R3/R8 applied value",
          int'({dvm_en[p], snoop_en[p]}), int'(e));
      chk(chg_req[p] == 1'b0, "R3 request dropped", int'(chg_req[p]), 0);
      rd(STAT_ADDR, rv);
      chk(rv == 0, "R4 idle after ack", int'(rv), 0);
      rd(port_addr(p), rv);
      chk(rv == DW'(e), "R9 readback", int'(rv), int'(e));
    end

    // R5, R6, R3: queued writes while in flight on port 1 (applied = 2)
    wr(port_addr(1), 3);
    step(1);
    chk(chg_req[1] && chg_snoop[1] && chg_dvm[1], "R2 offer 3", int'({chg_dvm[1], chg_snoop[1]}), 3);
    wr(port_addr(1), 1);
    wr(port_addr(1), 0);
    step(2);
    chk(chg_req[1] && {chg_dvm[1], chg_snoop[1]} == 2'b11, "R5 offer held",
        int'({chg_dvm[1], chg_snoop[1]}), 3);
    chk({dvm_en[1], snoop_en[1]} == 2'b10, "R3 no change without ack",
        int'({dvm_en[1], snoop_en[1]}), 2);
    ack(1);
    chk({dvm_en[1], snoop_en[1]} == 2'b11, "R3 first value applied",
        int'({dvm_en[1], snoop_en[1]}), 3);
    rd(STAT_ADDR, rv);
    chk(rv[0] == 1'b1, "R4 busy with queued write", int'(rv[0]), 1);
    chk(chg_req[1] && {chg_dvm[1], chg_snoop[1]} == 2'b00, "R6 latest value offered",
        int'({chg_dvm[1], chg_snoop[1]}), 0);
    ack(1);
    chk({dvm_en[1], snoop_en[1]} == 2'b00, "R6 latest value applied",
        int'({dvm_en[1], snoop_en[1]}), 0);
    rd(STAT_ADDR, rv);
    chk(rv == 0, "R4 idle after queue", int'(rv), 0);

    // R7: snoop disable waits for outstanding snoops on port 0
    apply(0, 2'b11);
    pulse_start(0);
    pulse_start(0);
    wr(port_addr(0), 0);
    step(3);
    chk(chg_req[0] == 1'b0, "R7 held with count 2", int'(chg_req[0]), 0);
    rd(STAT_ADDR, rv);
    chk(rv[0] == 1'b1, "R7 status busy while draining", int'(rv[0]), 1);
    pulse_end(0);
    step(2);
    chk(chg_req[0] == 1'b0, "R7 held with count 1", int'(chg_req[0]), 0);
    pulse_end(0);
    step(1);
    chk(chg_req[0] == 1'b1 && chg_snoop[0] == 1'b0, "R7 released at zero", int'(chg_req[0]), 1);
    ack(0);
    chk(snoop_en[0] == 1'b0, "R7 snoop off", int'(snoop_en[0]), 0);

    // R7: keeping snoop on is not held back
    apply(0, 2'b11);
    pulse_start(0);
    wr(port_addr(0), 1);
    step(1);
    chk(chg_req[0] == 1'b1, "R7 snoop kept, not held", int'(chg_req[0]), 1);
    ack(0);
    chk({dvm_en[0], snoop_en[0]} == 2'b01, "R7 dvm dropped", int'({dvm_en[0], snoop_en[0]}), 1);
    pulse_end(0);

    // R9: unmapped writes and reads
    wr(16'h0000, 3);
    wr(port_addr(2) | 16'h0004, 3);
    wr(16'h6000, 3);
    step(2);
    chk(chg_req == '0, "R9 unmapped write no request", int'(chg_req), 0);
    rd(STAT_ADDR, rv);
    chk(rv == 0, "R9 unmapped write no pending", int'(rv), 0);
    rd(port_addr(0) | 16'h0004, rv);
    chk(rv == 0, "R9 unmapped read zero", int'(rv), 0);
    rd(16'h6000, rv);
    chk(rv == 0, "R9 window past ports reads zero", int'(rv), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule